// File: doc/BRIEF.md
# Programmable Interrupt Source Allocator

The block takes eight interrupt request inputs and maps them onto three internal interrupt lines of falling priority. Each request input is edge detected and sets a sticky pending flag. A 16-bit allocation register holds two encoded selectors. Each selector names the one source that drives one of the two upper lines. The register also holds eight enable bits. The enabled sources that neither selector names are ORed together onto the third, lowest line.

A status word shows every pending flag, whether or not the source is routed anywhere. An interrupt handler on the third line can therefore tell which source raised it and choose its own order among them. The same word also supports a purely polled mode. Software clears a pending flag by writing a one to its status bit. A peripheral can clear its own flag through a dedicated clear strobe.

Source codes are fixed: 0 converter-finish, 1 SPI, 2 timer0, 3 timer1, 4 timer2, 5 external request 0, 6 external request 1, 7 external request 2. Input `irq_req[i]` carries source code i.

Top module: `ialloc_top`

## Requirements
- R1: After a synchronous active-low reset, the allocation word reads 0x00FF, the status word reads 0x0000, and all three lines are low.
- R2: A 0-to-1 transition of `irq_req[i]`, seen at a clock edge, sets pending bit i at that edge. A request held high sets the bit only once; after the bit is cleared it stays clear while the input remains high.
- R3: A pending bit stays set until it is cleared. A write with `bus_sel`=1 clears every status bit whose `bus_wdata[7:0]` bit is 1. Bits written 0 are not changed.
- R4: Asserting `src_clr[i]` for one cycle clears pending bit i at the next edge.
- R5: When a rising request and a clear of the same bit fall in the same cycle, the bit ends set.
- R6: `line_hi` equals pending bit `alloc[3:0]` when that code is 0..7. For codes 8..15 it stays low.
- R7: `line_mid` equals pending bit `alloc[7:4]` when that code is 0..7. For codes 8..15 it stays low.
- R8: `line_lo` is the OR over every source i with enable `alloc[8+i]`=1 that neither selector names, of pending bit i. A source that is neither selected nor enabled drives no line.
- R9: When both selectors hold the same code, `line_hi` and `line_mid` both follow that source, and the source is excluded from `line_lo` even if its enable bit is set.
- R10: The status word (`bus_sel`=1, bits [7:0] = pending bits, bits [15:8] = 0) records requests from all sources regardless of the enables and selectors.
- R11: A write with `bus_sel`=0 loads all 16 bits of the allocation word, which reads back on `bus_rdata` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 8 | Raw request inputs, bit i is source code i |
| src_clr | input | 8 | Per-source clear strobes |
| bus_sel | input | 1 | Register select: 0 allocation word, 1 status word |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| line_hi | output | 1 | Highest-priority internal interrupt line |
| line_mid | output | 1 | Second-priority internal interrupt line |
| line_lo | output | 1 | Lowest-priority merged interrupt line |

## Verification
The bench targets these cases:
- Selector codes 8 to 15. A decoder that looks only at the low three bits would route a source onto a disabled line.
- Two selectors naming the same source. A wrong design would either drop one upper line or let the source leak onto `line_lo` through its enable bit.
- A clear that coincides with a new rising edge. A design that lets the clear win loses that request.
- A request held high across a clear. A level-sensitive design would set the bit again at once.
- Requests on fully disabled sources. These must still appear in the status word while every line stays low.

// File: rtl/ialloc_pkg.sv
// Package: shared sizes and field helpers for the interrupt allocator.
// Assumes source count fits the selector width (NUM_SRC <= 2**SEL_W).
package ialloc_pkg;
    localparam int NUM_SRC = 8;
    localparam int SEL_W   = 4;
    localparam int REG_W   = 16;
    localparam int EN_LSB  = 2 * SEL_W;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [SEL_W-1:0]   sel_t;

    typedef struct packed {
        src_vec_t en;
        sel_t     sel_mid;
        sel_t     sel_hi;
    } alloc_t;

    localparam alloc_t ALLOC_RST = '{en: '0, sel_mid: '1, sel_hi: '1};
endpackage

// File: rtl/ialloc_pending.sv
// Module: edge detection and sticky pending flags per source.
// Assumes requests are already synchronous to clk. Set wins over clear.
module ialloc_pending #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] req_q;
    logic [N-1:0] rise;

    // Rising-edge vector of the raw requests.
    assign rise = req & ~req_q;

    // Register previous request levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req;
    end

    // Sticky pending bits: clear first, then merge new edges.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | rise;
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((pend & $past(rise)) == $past(rise)));
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ($past(pend) & ~$past(clr))) == ($past(pend) & ~$past(clr))));
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |=> ((pend & $past(clr) & ~$past(rise)) == '0));
    assert_win_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise & clr)) |=> ((pend & $past(rise & clr)) == $past(rise & clr)));
endmodule

// File: rtl/ialloc_regs.sv
// Module: allocation register and status access over a simple bus.
// Assumes a single-cycle write strobe; read data is combinational.
module ialloc_regs
    import ialloc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    input  src_vec_t         pend,
    input  src_vec_t         src_clr,
    output alloc_t           alloc,
    output src_vec_t         clr_all,
    output logic [REG_W-1:0] bus_rdata
);
    logic alloc_we;
    logic stat_we;

    assign alloc_we = bus_wr && !bus_sel;
    assign stat_we  = bus_wr &&  bus_sel;

    // Allocation word, disabled selectors and no enables after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        alloc <= ALLOC_RST;
        else if (alloc_we) alloc <= alloc_t'(bus_wdata);
    end

    // Combine write-one-to-clear mask with the hardware clear strobes.
    always_comb begin
        clr_all = src_clr;
        if (stat_we) clr_all = clr_all | bus_wdata[NUM_SRC-1:0];
    end

    // Read mux for the two registers.
    always_comb begin
        if (bus_sel) bus_rdata = {{(REG_W-NUM_SRC){1'b0}}, pend};
        else         bus_rdata = alloc;
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (alloc == ALLOC_RST));
    assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_we |=> (alloc == $past(bus_wdata)));
    assert_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_we |=> $stable(alloc));
endmodule

// File: rtl/ialloc_route.sv
// Module: maps pending flags onto the three prioritized lines.
// Assumes selector codes of NUM_SRC and above mean "line off".
module ialloc_route
    import ialloc_pkg::*;
(
    input  alloc_t   alloc,
    input  src_vec_t pend,
    output logic     line_hi,
    output logic     line_mid,
    output logic     line_lo
);
    src_vec_t hit_hi;
    src_vec_t hit_mid;
    src_vec_t claim;

    // Per-source decode of both selectors.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
        assign hit_hi[i]  = (alloc.sel_hi  == sel_t'(i));
        assign hit_mid[i] = (alloc.sel_mid == sel_t'(i));
    end

    assign claim = hit_hi | hit_mid;

    // Line outputs from decoded selectors and enables.
    always_comb begin
        line_hi  = |(hit_hi  & pend);
        line_mid = |(hit_mid & pend);
        line_lo  = |(pend & alloc.en & ~claim);
    end

    always_comb begin
        assert_off_R6: assert (!(alloc.sel_hi  >= sel_t'(NUM_SRC)) || !line_hi);
        assert_off_R7: assert (!(alloc.sel_mid >= sel_t'(NUM_SRC)) || !line_mid);
        assert_lo_R8:  assert (!line_lo || (|(pend & alloc.en)));
        assert_same_R9: assert (!(alloc.sel_hi == alloc.sel_mid) || (line_hi == line_mid));
    end
endmodule

// File: rtl/ialloc_top.sv
// Module: top of the interrupt source allocator.
// Assumes synchronous inputs and a single clock domain.
module ialloc_top
    import ialloc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       irq_req,
    input  logic [7:0]       src_clr,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [15:0]      bus_wdata,
    output logic [15:0]      bus_rdata,
    output logic             line_hi,
    output logic             line_mid,
    output logic             line_lo
);
    src_vec_t pend;
    src_vec_t clr_all;
    alloc_t   alloc;

    ialloc_pending #(.N(NUM_SRC)) i_pend (
        .clk(clk), .rst_n(rst_n), .req(irq_req), .clr(clr_all), .pend(pend)
    );

    ialloc_regs i_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .pend(pend), .src_clr(src_clr),
        .alloc(alloc), .clr_all(clr_all), .bus_rdata(bus_rdata)
    );

    ialloc_route i_route (
        .alloc(alloc), .pend(pend),
        .line_hi(line_hi), .line_mid(line_mid), .line_lo(line_lo)
    );
endmodule

// File: tb/test_ialloc_top.sv
module test_ialloc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_req = '0;
    logic [7:0]  src_clr = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        line_hi, line_mid, line_lo;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0]  m_pend = '0;
    logic [7:0]  m_prev = '0;
    logic [15:0] m_alloc = 16'h00FF;

    always #5 clk = ~clk;

    ialloc_top i_ialloc_top (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .src_clr(src_clr),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .line_hi(line_hi), .line_mid(line_mid), .line_lo(line_lo)
    );

    function automatic logic exp_sel(input logic [3:0] s, input logic [7:0] p);
        return (s < 4'd8) ? p[s[2:0]] : 1'b0;
    endfunction

    function automatic logic exp_lo(input logic [15:0] a, input logic [7:0] p);
        logic [7:0] m = p & a[15:8];
        if (a[3:0] < 4'd8) m[a[2:0]] = 1'b0;
        if (a[7:4] < 4'd8) m[a[6:4]] = 1'b0;
        return |m;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Drive inputs for one cycle, update the model at the edge, return at negedge.
    task automatic step(input logic [7:0] req, input logic [7:0] clr,
                        input logic wr, input logic sel, input logic [15:0] wd);
        logic [7:0] cm;
        irq_req = req; src_clr = clr; bus_wr = wr; bus_sel = sel; bus_wdata = wd;
        @(posedge clk);
        cm = clr | ((wr && sel) ? wd[7:0] : 8'h00);
        m_pend = (m_pend & ~cm) | (req & ~m_prev);
        m_prev = req;
        if (wr && !sel) m_alloc = wd;
        @(negedge clk);
        bus_wr = 1'b0; src_clr = '0;
    endtask

    task automatic chk_lines(input string tag);
        chk({tag, " hi"},  {15'd0, line_hi},  {15'd0, exp_sel(m_alloc[3:0], m_pend)});
        chk({tag, " mid"}, {15'd0, line_mid}, {15'd0, exp_sel(m_alloc[7:4], m_pend)});
        chk({tag, " lo"},  {15'd0, line_lo},  {15'd0, exp_lo(m_alloc, m_pend)});
    endtask

    task automatic chk_regs(input string tag);
        bus_sel = 1'b1; #1;
        chk({tag, " status"}, bus_rdata, {8'h00, m_pend});
        bus_sel = 1'b0; #1;
        chk({tag, " alloc"}, bus_rdata, m_alloc);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] req;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk_regs("R1");
        chk("R1 lines", {13'd0, line_hi, line_mid, line_lo}, 16'd0);

        // R10: requests recorded with everything disabled, lines stay low
        step(8'hA5, 0, 0, 0, 0);
        chk_regs("R10");
        chk("R10 lines", {13'd0, line_hi, line_mid, line_lo}, 16'd0);

        // R2: held request is not re-pended after W1C
        step(8'hA5, 0, 1, 1, 16'h00FF);
        step(8'hA5, 0, 0, 0, 0);
        chk_regs("R2 held");
        step(8'h00, 0, 0, 0, 0);
        step(8'h01, 0, 0, 0, 0);
        chk_regs("R2 edge");

        // R3: write zeros leaves bits, ones clear only selected bits
        step(8'h07, 0, 0, 0, 0);
        step(8'h07, 0, 1, 1, 16'hFF00);
        chk_regs("R3 zero");
        step(8'h07, 0, 1, 1, 16'h0002);
        chk_regs("R3 w1c");

        // R4: clear strobe
        step(8'h07, 8'h04, 0, 0, 0);
        chk_regs("R4");

        // R5: rise with simultaneous clear
        step(8'h00, 0, 0, 0, 0);
        step(8'h01, 8'h01, 0, 0, 0);
        chk_regs("R5");

        // R11: allocation load; R6/R7: select sources 0 and 3
        step(8'h00, 0, 1, 0, 16'hFF30);
        chk_regs("R11");
        step(8'h08, 0, 0, 0, 0);
        chk_lines("R6 R7");

        // R6: codes 8..15 disable high line even if low bits hit
        step(8'h00, 0, 1, 0, 16'h0009);
        chk_lines("R6 off");
        // R7: code 8..15 for mid line
        step(8'h00, 0, 1, 0, 16'h00B0);
        chk_lines("R7 off");

        // R9: same code on both selectors, enable set for it
        step(8'h00, 0, 1, 1, 16'h00FF);
        step(8'h00, 0, 1, 0, 16'h0422);
        step(8'h04, 0, 0, 0, 0);
        chk_lines("R9");
        chk("R9 lo", {15'd0, line_lo}, 16'd0);

        // R8: merged line from enabled unclaimed source
        step(8'h00, 0, 1, 0, 16'h2010);
        step(8'h20, 0, 0, 0, 0);
        chk_lines("R8");
        chk("R8 lo", {15'd0, line_lo}, 16'd1);

        // Random mix for R2..R11
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r = $urandom;
            logic [15:0] wd = 16'($urandom);
            req = ($urandom % 3 == 0) ? 8'($urandom) : m_prev;
            step(req, (r[3:0] == 0) ? 8'($urandom) : 8'h00, r[6:4] == 0, r[7], wd);
            chk_lines("R6 R7 R8 rnd");
            if (k % 4 == 0) chk_regs("R3 R10 R11 rnd");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule